// File: doc/BRIEF.md
# Vertex Microinstruction Decoder and Simple-Operation Unit

This block sits at the front of a per-vertex floating-point datapath. Each cycle it may accept one 32-bit microinstruction. It splits the word into two source register indices, a 4-bit opcode and a 7-bit destination index. The two source indices come out combinationally, so a register file can return the operands in the same cycle. Flag register 2 is supplied alongside them.

One clock later the block presents a registered result. That result carries the opcode, the destination, and the fixed pipeline latency that the scheduler uses to place the write-back. It also carries a class flag that says where the value comes from:
- computed here: no-op, magnitude, copy, ordered compare, equality compare, flag select, sign transfer and reciprocal-square-root seed;
- to be computed by an external arithmetic unit: add, subtract, multiply, the two conversions, sine and cosine;
- the vector-output opcode, which ends a vertex program.

Comparisons return the single-precision constants 1.0 and 0.0 rather than a bit.

Top module: `vxu_simple_unit`

## Requirements
- R1: `src_a_idx` equals insn[24:18] and `src_b_idx` equals insn[17:11] in the same cycle. One clock after an accepted instruction, `out_op` equals insn[10:7] and `out_dst` equals insn[6:0]. Bits 31:25 are ignored.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, every other output keeps its value. After reset, all outputs are zero.
- R3: `out_lat` has these values: 5 for opcodes 1 and 2, 7 for opcode 3, 3 for opcode 6, 4 for opcodes 8 and 9, 0 for opcodes 0 and 7, and 2 for opcodes 4, 5 and 10 to 15.
- R4: Exactly one of three class flags is high. `out_ext` is high for opcodes 1, 2, 3, 5, 6, 8 and 9, and `out_result` is then 0. `out_vecout` is high for opcode 7, and `out_result` is then 0. `out_local` is high for all other opcodes.
- R5: Opcode 0 gives result 0. Opcode 4 gives A with bit 31 cleared. Opcode 12 gives A unchanged.
- R6: Opcode 10 gives 0x3F800000 when A > B as floats, and 0 otherwise. +0 and -0 compare equal, and a NaN operand gives 0.
- R7: Opcode 11 gives 0x3F800000 when A == B as floats, and 0 otherwise. +0 equals -0, and a NaN operand gives 0.
- R8: Opcode 13 gives A when `flag_val` is nonzero, and B otherwise.
- R9: Opcode 14 gives A with bit 31 inverted when B is negative, and A otherwise. B counts as negative when its sign is set and it is neither a zero nor a NaN.
- R10: Opcode 15 gives 0x5F3759DF minus (A shifted right by one), computed on the raw bits modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 32 | Microinstruction word |
| opa_val | input | 32 | Value of source register A |
| opb_val | input | 32 | Value of source register B |
| flag_val | input | 32 | Value of flag register 2 |
| src_a_idx | output | 7 | Source A index, combinational |
| src_b_idx | output | 7 | Source B index, combinational |
| out_valid | output | 1 | Registered result is new this cycle |
| out_op | output | 4 | Registered opcode |
| out_dst | output | 7 | Registered destination index |
| out_lat | output | 4 | Fixed latency of the opcode |
| out_result | output | 32 | Result of a locally computed opcode |
| out_local | output | 1 | Result computed in this block |
| out_ext | output | 1 | Opcode handled by an external unit |
| out_vecout | output | 1 | Vector-output opcode |

## Verification
The hardest cases to reach are the float corner cases. They need operand pairs in which a sign bit disagrees with the value order: both operands negative, a zero of either sign against the other zero, and NaNs carrying either sign, including a negative NaN or a negative zero in B for the sign transfer. Random 32-bit words almost never produce these. The stimulus therefore runs a directed table of such pairs across the above, equal and sign-transfer opcodes. It then runs random words, with a quarter of the operands drawn from a small set of special values (±0, ±1, ±Inf, NaNs). Idle cycles are scattered between instructions, so that the hold behaviour is compared on every clock against the bench's model.

// File: rtl/vxu_simple_unit.sv
`timescale 1ns/1ps
module vxu_simple_unit #(
  parameter logic [31:0] RSQRT_MAGIC = 32'h5F3759DF,
  parameter logic [31:0] FLOAT_ONE   = 32'h3F800000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] insn,
  input  logic [31:0] opa_val,
  input  logic [31:0] opb_val,
  input  logic [31:0] flag_val,
  output logic [6:0]  src_a_idx,
  output logic [6:0]  src_b_idx,
  output logic        out_valid,
  output logic [3:0]  out_op,
  output logic [6:0]  out_dst,
  output logic [3:0]  out_lat,
  output logic [31:0] out_result,
  output logic        out_local,
  output logic        out_ext,
  output logic        out_vecout
);
  localparam logic [3:0] OP_NOP = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_MUL = 4'd3;
  localparam logic [3:0] OP_ABS = 4'd4,  OP_F2I = 4'd5,  OP_I2F = 4'd6,  OP_VEC = 4'd7;
  localparam logic [3:0] OP_SIN = 4'd8,  OP_COS = 4'd9,  OP_GT  = 4'd10, OP_EQ  = 4'd11;
  localparam logic [3:0] OP_CPY = 4'd12, OP_SEL = 4'd13, OP_SGN = 4'd14, OP_RSQ = 4'd15;

  logic [3:0] op_c;
  logic [6:0] dst_c;
  logic       a_nan, b_nan, a_zero, b_zero, any_nan, both_zero;
  logic       mag_gt, mag_eq, a_gt_b, a_eq_b, b_neg;
  logic [31:0] res_c;
  logic [3:0]  lat_c;
  logic        loc_c, ext_c, vec_c;

  assign src_a_idx = insn[24:18];
  assign src_b_idx = insn[17:11];
  assign op_c      = insn[10:7];
  assign dst_c     = insn[6:0];

  assign a_nan     = (opa_val[30:23] == 8'hFF) && (opa_val[22:0] != 23'd0);
  assign b_nan     = (opb_val[30:23] == 8'hFF) && (opb_val[22:0] != 23'd0);
  assign a_zero    = (opa_val[30:0] == 31'd0);
  assign b_zero    = (opb_val[30:0] == 31'd0);
  assign any_nan   = a_nan | b_nan;
  assign both_zero = a_zero & b_zero;
  assign mag_gt    = opa_val[30:0] > opb_val[30:0];
  assign mag_eq    = opa_val[30:0] == opb_val[30:0];
  assign b_neg     = opb_val[31] & ~b_zero & ~b_nan;

  always_comb begin
    a_gt_b = 1'b0;
    if (!any_nan && !both_zero) begin
      case ({opa_val[31], opb_val[31]})
        2'b00:   a_gt_b = mag_gt;
        2'b01:   a_gt_b = 1'b1;
        2'b10:   a_gt_b = 1'b0;
        default: a_gt_b = ~mag_gt & ~mag_eq;
      endcase
    end
  end

  assign a_eq_b = !any_nan && (both_zero || (mag_eq && opa_val[31] == opb_val[31]));

  always_comb begin
    res_c = 32'd0;
    lat_c = 4'd2;
    loc_c = 1'b1;
    ext_c = 1'b0;
    vec_c = 1'b0;
    case (op_c)
      OP_NOP: lat_c = 4'd0;
      OP_ADD, OP_SUB: begin lat_c = 4'd5; loc_c = 1'b0; ext_c = 1'b1; end
      OP_MUL:         begin lat_c = 4'd7; loc_c = 1'b0; ext_c = 1'b1; end
      OP_F2I:         begin lat_c = 4'd2; loc_c = 1'b0; ext_c = 1'b1; end
      OP_I2F:         begin lat_c = 4'd3; loc_c = 1'b0; ext_c = 1'b1; end
      OP_SIN, OP_COS: begin lat_c = 4'd4; loc_c = 1'b0; ext_c = 1'b1; end
      OP_VEC:         begin lat_c = 4'd0; loc_c = 1'b0; vec_c = 1'b1; end
      OP_ABS: res_c = {1'b0, opa_val[30:0]};
      OP_GT:  res_c = a_gt_b ? FLOAT_ONE : 32'd0;
      OP_EQ:  res_c = a_eq_b ? FLOAT_ONE : 32'd0;
      OP_CPY: res_c = opa_val;
      OP_SEL: res_c = (flag_val != 32'd0) ? opa_val : opb_val;
      OP_SGN: res_c = {opa_val[31] ^ b_neg, opa_val[30:0]};
      OP_RSQ: res_c = RSQRT_MAGIC - {1'b0, opa_val[31:1]};
      default: res_c = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_op     <= 4'd0;
      out_dst    <= 7'd0;
      out_lat    <= 4'd0;
      out_result <= 32'd0;
      out_local  <= 1'b0;
      out_ext    <= 1'b0;
      out_vecout <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_op     <= op_c;
        out_dst    <= dst_c;
        out_lat    <= lat_c;
        out_result <= res_c;
        out_local  <= loc_c;
        out_ext    <= ext_c;
        out_vecout <= vec_c;
      end
    end
  end
endmodule

module vxu_simple_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [3:0]  out_op,
  input logic [3:0]  out_lat,
  input logic [31:0] out_result,
  input logic        out_local,
  input logic        out_ext,
  input logic        out_vecout
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_result) && $stable(out_op)); // R2
  AST_ONE_CLASS:     assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $countones({out_local, out_ext, out_vecout}) == 1); // R4
  AST_VEC_NO_LAT:    assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_vecout) |-> out_lat == 4'd0); // R3
  AST_EXT_ZERO:      assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ext) |-> out_result == 32'd0); // R4
  AST_ABS_POS:       assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_op == 4'd4) |-> !out_result[31]); // R5
  AST_GT_CONST:      assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_op == 4'd10) |-> (out_result == 32'h3F800000 || out_result == 32'd0)); // R6
  AST_EQ_CONST:      assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_op == 4'd11) |-> (out_result == 32'h3F800000 || out_result == 32'd0)); // R7
endmodule

bind vxu_simple_unit vxu_simple_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_op(out_op), .out_lat(out_lat), .out_result(out_result),
  .out_local(out_local), .out_ext(out_ext), .out_vecout(out_vecout)
);

// File: tb/vxu_simple_unit_bench.sv
`timescale 1ns/1ps
module vxu_simple_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0, opa_val = '0, opb_val = '0, flag_val = '0;
  logic [6:0] src_a_idx, src_b_idx, out_dst;
  logic out_valid, out_local, out_ext, out_vecout;
  logic [3:0] out_op, out_lat;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  bit          m_valid = 0;
  logic [3:0]  m_op = 0, m_lat = 0;
  logic [6:0]  m_dst = 0;
  logic [31:0] m_res = 0;
  logic [2:0]  m_cls = 0; // {local, ext, vec}

  always #(CLK_PERIOD/2) clk = ~clk;

  vxu_simple_unit u_vxu_simple_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .opa_val(opa_val), .opb_val(opb_val), .flag_val(flag_val),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .out_valid(out_valid),
    .out_op(out_op), .out_dst(out_dst), .out_lat(out_lat), .out_result(out_result),
    .out_local(out_local), .out_ext(out_ext), .out_vecout(out_vecout)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic [31:0] okey(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    if (x[31]) return ~x;
    return x | 32'h8000_0000;
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd10: return "R6";
      4'd11: return "R7";
      4'd13: return "R8";
      4'd14: return "R9";
      4'd15: return "R10";
      4'd0, 4'd4, 4'd12: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic compare_outputs();
    chk("R2", "out_valid", {31'd0, out_valid}, {31'd0, m_valid});
    chk("R1", "out_op", {28'd0, out_op}, {28'd0, m_op});
    chk("R1", "out_dst", {25'd0, out_dst}, {25'd0, m_dst});
    chk("R3", "out_lat", {28'd0, out_lat}, {28'd0, m_lat});
    chk("R4", "class", {29'd0, out_local, out_ext, out_vecout}, {29'd0, m_cls});
    chk(req_of(m_op), "out_result", out_result, m_res);
  endtask

  task automatic step(input bit v, input logic [3:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] f);
    logic [6:0] ra, rb, rd;
    @(negedge clk);
    compare_outputs();
    ra = 7'($urandom); rb = 7'($urandom); rd = 7'($urandom);
    in_valid = v;
    insn = {7'($urandom), ra, rb, op, rd};
    opa_val = a; opb_val = b; flag_val = f;
    #1;
    chk("R1", "src_a_idx", {25'd0, src_a_idx}, {25'd0, ra});
    chk("R1", "src_b_idx", {25'd0, src_b_idx}, {25'd0, rb});
    m_valid = v;
    if (v) begin
      bit neg_b;
      m_op = op; m_dst = rd;
      m_res = 0;
      case (op)
        4'd1, 4'd2: begin m_lat = 5; m_cls = 3'b010; end
        4'd3:       begin m_lat = 7; m_cls = 3'b010; end
        4'd5:       begin m_lat = 2; m_cls = 3'b010; end
        4'd6:       begin m_lat = 3; m_cls = 3'b010; end
        4'd8, 4'd9: begin m_lat = 4; m_cls = 3'b010; end
        4'd7:       begin m_lat = 0; m_cls = 3'b001; end
        4'd0:       begin m_lat = 0; m_cls = 3'b100; end
        default:    begin m_lat = 2; m_cls = 3'b100; end
      endcase
      neg_b = !is_nan(b) && okey(b) < 32'h8000_0000;
      case (op)
        4'd4:  m_res = a & 32'h7FFF_FFFF;
        4'd10: m_res = (!is_nan(a) && !is_nan(b) && okey(a) > okey(b)) ? 32'h3F80_0000 : 0;
        4'd11: m_res = (!is_nan(a) && !is_nan(b) && okey(a) == okey(b)) ? 32'h3F80_0000 : 0;
        4'd12: m_res = a;
        4'd13: m_res = (f != 0) ? a : b;
        4'd14: m_res = neg_b ? (a ^ 32'h8000_0000) : a;
        4'd15: m_res = 32'h5F37_59DF - (a >> 1);
        default: m_res = 0;
      endcase
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] sp [8] = '{32'h0, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
                             32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 32'hFFC0_0001};
    if ($urandom_range(3) == 0) return sp[$urandom_range(7)];
    return $urandom;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] cv [12] = '{32'h0, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
                              32'hC000_0000, 32'h4000_0000, 32'h7F80_0000, 32'hFF80_0000,
                              32'h7FC0_0000, 32'hFFC0_0001, 32'h0000_0001, 32'h8000_0001};
    repeat (3) @(negedge clk);
    // reset state (R2)
    chk("R2", "reset out_valid", {31'd0, out_valid}, 0);
    chk("R2", "reset out_result", out_result, 0);
    chk("R2", "reset class", {29'd0, out_local, out_ext, out_vecout}, 0);
    rst_n = 1'b1;
    // every opcode once (R3, R4, R5)
    for (int op = 0; op < 16; op++) step(1, 4'(op), 32'hC123_4567, 32'h4000_0000, 32'd1);
    // compare and sign corner pairs (R6, R7, R9)
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++) begin
        step(1, 4'd10, cv[i], cv[j], 0);
        step(1, 4'd11, cv[i], cv[j], 0);
        step(1, 4'd14, cv[j], cv[i], 0);
      end
    // flag select both ways (R8)
    step(1, 4'd13, 32'h1111_1111, 32'h2222_2222, 32'h0);
    step(1, 4'd13, 32'h1111_1111, 32'h2222_2222, 32'h8000_0000);
    // rsqrt seed wrap (R10)
    step(1, 4'd15, 32'hFFFF_FFFF, 0, 0);
    step(1, 4'd15, 32'h0, 0, 0);
    // hold across idle (R2)
    step(1, 4'd12, 32'hDEAD_BEEF, 0, 0);
    step(0, 4'd4, 32'h1234_5678, 0, 0);
    step(0, 4'd15, 32'h0, 0, 0);
    // random traffic
    for (int k = 0; k < 3000; k++)
      step($urandom_range(4) != 0, 4'($urandom), pick(), pick(), ($urandom_range(1) == 0) ? 0 : $urandom);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    finish_run();
  end
endmodule